// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Aggregator

This block collects a build-time number of interrupt banks, each serving 32 level-sensitive request lines, and presents them to software through one small synchronous register port. Every bank has its own copy of five registers, and each copy sits at a fixed 32-byte stride in the address space. Software can read the raw input levels, the mask and the masked (pending) view. It changes the mask only through two write-only registers. One register sets mask bits and the other clears them, so no read-modify-write is needed.

All pending lines across every bank are OR-ed into a single registered request toward a parent interrupt controller. Software finds the source by scanning the pending register of each bank. Line `n` belongs to bank `n / 32` at bit `n % 32`.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every mask bit is 1, `irq_out` is 0 and `rd_data` is 0.
- R2: Bank b decodes byte addresses b*0x20 + offset. The offsets are 0x00 raw status, 0x04 mask, 0x08 set-mask, 0x0C clear-mask and 0x10 pending. Bit i of a bank's registers corresponds to input line 32*b+i.
- R3: A write to set-mask sets every mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A write to clear-mask clears every mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: Pending reads as raw status AND NOT mask. It follows the current input level and is never latched. Raw status reads the current input level.
- R6: `irq_out` equals the OR of all pending bits of all banks as they stood one clock earlier.
- R7: Writes to the raw status, mask and pending offsets leave every mask bit unchanged.
- R8: The set-mask and clear-mask offsets read as zero.
- R9: Any other offset within a bank, including a misaligned one, and any bank number at or above NUM_BANKS reads as zero. Writes to such addresses change no mask bit.
- R10: `rd_data` shows the addressed register one clock after a cycle with `rd_en` high. It is zero one clock after a cycle with `rd_en` low.
- R11: A build with NUM_BANKS=1 behaves as a single 32-line controller at offsets 0x00 to 0x10. Addresses from 0x20 upward read zero and are ignored on write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_BANKS*32 | Level-sensitive request lines, synchronous to clk |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for this cycle |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The two functions that can land in the same cycle are a mask update and a change of a request line's level. The bench raises a masked line on the same edge that its clear-mask write commits. It then sets the mask of a line that is already asserted on the same edge. In both cases it judges `irq_out` on the two following clocks: the first must still reflect the old mask, and the second the new one. It also reads pending and raw status in these states to confirm that the raw level is unaffected by the mask.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int LINES   = 32;
  localparam int OFS_W   = 5;   // 32-byte stride per bank

  localparam logic [OFS_W-1:0] OFS_RAW  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_MASK = 5'h04;
  localparam logic [OFS_W-1:0] OFS_SETM = 5'h08;
  localparam logic [OFS_W-1:0] OFS_CLRM = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_PEND = 5'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_MASK,
    SEL_SETM,
    SEL_CLRM,
    SEL_PEND
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      OFS_RAW:  return SEL_RAW;
      OFS_MASK: return SEL_MASK;
      OFS_SETM: return SEL_SETM;
      OFS_CLRM: return SEL_CLRM;
      OFS_PEND: return SEL_PEND;
      default:  return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_bank_regdec.sv
module irq_bank_regdec
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output reg_sel_e             sel
);
  localparam int BANK_IDX_W = ADDR_W - OFS_W;

  logic [BANK_IDX_W-1:0] bank_idx;
  assign bank_idx = addr[ADDR_W-1:OFS_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bank_hit[b] = (bank_idx == BANK_IDX_W'(b));
  end

  always_comb begin
    if (|bank_hit) sel = decode_ofs(addr[OFS_W-1:0]);
    else           sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_bank_slice.sv
module irq_bank_slice
  import irq_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lines,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] pend
);
  logic [LINES-1:0] set_bits;
  logic [LINES-1:0] clr_bits;

  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= (mask_q | set_bits) & ~clr_bits;
  end

  assign pend = lines & ~mask_q;
endmodule

// File: rtl/irq_bank_rdmux.sv
module irq_bank_rdmux
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [NUM_BANKS-1:0]         bank_hit,
  input  reg_sel_e                     sel,
  input  logic [NUM_BANKS*LINES-1:0]   raw_flat,
  input  logic [NUM_BANKS*LINES-1:0]   mask_flat,
  input  logic [NUM_BANKS*LINES-1:0]   pend_flat,
  output logic [LINES-1:0]             rd_data
);
  logic [LINES-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (sel)
          SEL_RAW:  rd_next = rd_next | raw_flat [b*LINES +: LINES];
          SEL_MASK: rd_next = rd_next | mask_flat[b*LINES +: LINES];
          SEL_PEND: rd_next = rd_next | pend_flat[b*LINES +: LINES];
          default:  rd_next = rd_next;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rd_data <= '0;
    else               rd_data <= rd_next;
  end
endmodule

// File: rtl/irq_bank_merge.sv
module irq_bank_merge
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_BANKS*LINES-1:0] pend_flat,
  output logic                       irq_q
);
  logic [NUM_BANKS-1:0] bank_any;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_any
    assign bank_any[b] = |pend_flat[b*LINES +: LINES];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |bank_any;
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_BANKS*32-1:0]    irq_in,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic [31:0]                wr_data,
  input  logic                       rd_en,
  output logic [31:0]                rd_data,
  output logic                       irq_out
);
  localparam int TOTAL = NUM_BANKS * LINES;

  logic [NUM_BANKS-1:0] bank_hit;
  reg_sel_e             sel;
  logic [TOTAL-1:0]     mask_arr;
  logic [TOTAL-1:0]     pend_arr;

  irq_bank_regdec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr     (addr),
    .bank_hit (bank_hit),
    .sel      (sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic set_we;
    logic clr_we;
    assign set_we = wr_en && bank_hit[b] && (sel == SEL_SETM);
    assign clr_we = wr_en && bank_hit[b] && (sel == SEL_CLRM);

    irq_bank_slice u_slice (
      .clk    (clk),
      .rst    (rst),
      .lines  (irq_in[b*LINES +: LINES]),
      .set_we (set_we),
      .clr_we (clr_we),
      .wdata  (wr_data),
      .mask_q (mask_arr[b*LINES +: LINES]),
      .pend   (pend_arr[b*LINES +: LINES])
    );
  end

  irq_bank_rdmux #(.NUM_BANKS(NUM_BANKS)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .bank_hit  (bank_hit),
    .sel       (sel),
    .raw_flat  (irq_in),
    .mask_flat (mask_arr),
    .pend_flat (pend_arr),
    .rd_data   (rd_data)
  );

  irq_bank_merge #(.NUM_BANKS(NUM_BANKS)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .pend_flat (pend_arr),
    .irq_q     (irq_out)
  );
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_BANKS*32-1:0] irq_in,
  input logic [ADDR_W-1:0]       addr,
  input logic                    wr_en,
  input logic [31:0]             wr_data,
  input logic                    rd_en,
  input logic [31:0]             rd_data,
  input logic                    irq_out,
  input logic [NUM_BANKS*32-1:0] mask_flat
);
  localparam int BANK_IDX_W = ADDR_W - 5;

  logic       armed;
  logic [4:0] ofs;
  logic       in_range;
  logic       mask_wr;

  assign ofs      = addr[4:0];
  assign in_range = (32'(addr[ADDR_W-1:5]) < NUM_BANKS);
  assign mask_wr  = wr_en && in_range && (ofs == 5'h08 || ofs == 5'h0C);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R6: merged request is the registered OR of all pending lines
  p_out_registered_r6: assert property (@(posedge clk) disable iff (rst)
    armed |-> (irq_out == $past(|(irq_in & ~mask_flat))));

  // R3: set-mask write on bank 0 sets the written bits
  p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(8)) |=>
      ((mask_flat[31:0] & $past(wr_data)) == $past(wr_data)));

  // R4: clear-mask write on bank 0 clears the written bits
  p_clr_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(12)) |=>
      ((mask_flat[31:0] & $past(wr_data)) == 32'h0));

  // R7, R9: no other access changes the mask
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(mask_flat));

  // R8: write-only registers read zero
  p_wo_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (ofs == 5'h08 || ofs == 5'h0C)) |=> (rd_data == 32'h0));

  // R10: no read strobe, zero read data
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == 32'h0));

  // R9: out-of-range bank reads zero
  p_range_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_range) |=> (rd_data == 32'h0));

  logic [BANK_IDX_W-1:0] unused_idx;
  assign unused_idx = addr[ADDR_W-1:5];
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_in    (irq_in),
  .addr      (addr),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .irq_out   (irq_out),
  .mask_flat (mask_arr)
);

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic [31:0] irq_in_1 = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        use_one = 1'b0;
  logic [31:0] rd_data_0, rd_data_1;
  logic        irq_out_0, irq_out_1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_bank_ctrl #(.NUM_BANKS(2), .ADDR_W(8)) u_irq_bank_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr),
    .wr_en(wr_en && !use_one), .wr_data(wr_data),
    .rd_en(rd_en && !use_one), .rd_data(rd_data_0), .irq_out(irq_out_0)
  );

  irq_bank_ctrl #(.NUM_BANKS(1), .ADDR_W(8)) u_irq_bank_ctrl_one (
    .clk(clk), .rst(rst), .irq_in(irq_in_1), .addr(addr),
    .wr_en(wr_en && use_one), .wr_data(wr_data),
    .rd_en(rd_en && use_one), .rd_data(rd_data_1), .irq_out(irq_out_1)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = use_one ? rd_data_1 : rd_data_0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "irq_out after reset", 32'(irq_out_0), 32'h0);
    chk("R1", "rd_data after reset", rd_data_0, 32'h0);
    rd(8'h04, v); chk("R1", "bank0 mask", v, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R1", "bank1 mask", v, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10", "rd_data idle", rd_data_0, 32'h0);
  endtask

  task automatic t_set_clear();
    logic [31:0] v;
    wr(8'h0C, 32'h0000_00F0);
    rd(8'h04, v); chk("R4", "clear bank0", v, 32'hFFFF_FF0F);
    wr(8'h08, 32'h0000_0030);
    rd(8'h04, v); chk("R3", "set bank0", v, 32'hFFFF_FF3F);
    wr(8'h2C, 32'h8000_0001);
    rd(8'h24, v); chk("R4", "clear bank1", v, 32'h7FFF_FFFE);
    wr(8'h28, 32'h0000_0001);
    rd(8'h24, v); chk("R3", "set bank1", v, 32'h7FFF_FFFF);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    @(negedge clk); irq_in[31:0] = 32'h0000_00C3;
    rd(8'h00, v); chk("R5", "raw bank0", v, 32'h0000_00C3);
    rd(8'h10, v); chk("R5", "pend bank0", v, 32'h0000_00C0);
    rd(8'h30, v); chk("R2", "pend bank1 idle", v, 32'h0);
    chk("R6", "irq_out with pending", 32'(irq_out_0), 32'h1);
    @(negedge clk); irq_in[31:0] = 32'h0;
    rd(8'h10, v); chk("R5", "pend follows level", v, 32'h0);
    chk("R6", "irq_out released", 32'(irq_out_0), 32'h0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    @(negedge clk); irq_in[63] = 1'b1;
    #1 chk("R6", "same cycle low", 32'(irq_out_0), 32'h0);
    @(negedge clk); chk("R6", "one cycle later high", 32'(irq_out_0), 32'h1);
    rd(8'h20, v); chk("R2", "bank1 raw bit31", v, 32'h8000_0000);
    rd(8'h30, v); chk("R2", "bank1 pend bit31", v, 32'h8000_0000);
    @(negedge clk); irq_in[63] = 1'b0;
    #1 chk("R6", "drop same cycle high", 32'(irq_out_0), 32'h1);
    @(negedge clk); chk("R6", "drop one cycle later", 32'(irq_out_0), 32'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h24, 32'h0);
    rd(8'h04, v); chk("R7", "bank0 mask kept", v, 32'hFFFF_FF3F);
    rd(8'h24, v); chk("R7", "bank1 mask kept", v, 32'h7FFF_FFFF);
    wr(8'h14, 32'h0);
    wr(8'h0D, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h6C, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R9", "bank0 mask kept", v, 32'hFFFF_FF3F);
    rd(8'h24, v); chk("R9", "bank1 mask kept", v, 32'h7FFF_FFFF);
    @(negedge clk); irq_in = '1;
    rd(8'h14, v); chk("R9", "unused offset", v, 32'h0);
    rd(8'h01, v); chk("R9", "misaligned offset", v, 32'h0);
    rd(8'h40, v); chk("R9", "bank2 raw", v, 32'h0);
    rd(8'h50, v); chk("R9", "bank2 pend", v, 32'h0);
    @(negedge clk); irq_in = '0;
  endtask

  task automatic t_wo_read();
    logic [31:0] v;
    rd(8'h08, v); chk("R8", "set-mask read", v, 32'h0);
    rd(8'h0C, v); chk("R8", "clear-mask read", v, 32'h0);
    rd(8'h2C, v); chk("R8", "bank1 clear-mask read", v, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    @(negedge clk);
    addr = 8'h0C; wr_data = 32'h0000_0100; wr_en = 1'b1; irq_in[8] = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R6", "unmask+rise first edge", 32'(irq_out_0), 32'h0);
    @(negedge clk);
    chk("R6", "unmask+rise second edge", 32'(irq_out_0), 32'h1);
    wr(8'h08, 32'h0000_0100);
    chk("R3", "mask while high first edge", 32'(irq_out_0), 32'h1);
    @(negedge clk);
    chk("R3", "mask while high second edge", 32'(irq_out_0), 32'h0);
    rd(8'h00, v); chk("R5", "raw keeps level when masked", v, 32'h0000_0100);
    rd(8'h10, v); chk("R5", "pend zero when masked", v, 32'h0);
    @(negedge clk); irq_in[8] = 1'b0;
  endtask

  task automatic t_one_bank();
    logic [31:0] v;
    use_one = 1'b1;
    @(negedge clk); irq_in_1 = 32'h0000_0003;
    wr(8'h0C, 32'h0000_0001);
    wr(8'h2C, 32'h0000_0002);
    @(negedge clk);
    chk("R11", "single bank irq_out", 32'(irq_out_1), 32'h1);
    rd(8'h10, v); chk("R11", "single bank pend", v, 32'h0000_0001);
    rd(8'h04, v); chk("R11", "single bank mask", v, 32'hFFFF_FFFE);
    rd(8'h20, v); chk("R11", "above range raw", v, 32'h0);
    rd(8'h30, v); chk("R11", "above range pend", v, 32'h0);
    use_one = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_pending();
    t_timing();
    t_ignored();
    t_wo_read();
    t_same_cycle();
    t_one_bank();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule